// File: doc/BRIEF.md
# DDR2 Row Activation Timing Monitor

This block sits passively on a DDR2 command bus and reports, cycle by cycle, every command that breaks one of the row-activation timing rules. It samples the chip select, RAS, CAS and write-enable strobes, a bank address and a row address on each rising clock edge. From these it recognises activate, read, write and precharge commands. For each of the eight banks it keeps an open/closed flag, a latched row and two saturating age counters: clocks since the last activate and clocks since the last precharge. One global counter holds the clocks since the most recent activate to any bank.

All timing limits are elaboration-time parameters in clock cycles. The additive latency is a live input, because it is programmed at run time. Each rule has its own error output. That output pulses for one cycle after the clock edge where the offending command was sampled. A vector shows which banks are open, and a row output reports the row that the latest read or write hit. The monitor is meant for simulation benches and for on-chip checking of a memory controller's command scheduler.

Top module: `ddr2_act_timing_mon`

## Requirements
- R1: Commands are decoded only with `cs_n` low. The strobe patterns on {`ras_n`,`cas_n`,`we_n`} are: activate 011, read 101, write 100, precharge 010. With `cs_n` high, or with any other pattern (refresh 001, mode-register 000, no-op 111), the bank state is unchanged and no rule error is raised. Every error output is registered, so it is visible during the clock cycle after the edge where the command was sampled.
- R2: An activate sets bit `ba` of `bank_open`. A precharge to an open bank clears that bit. A precharge to a closed bank changes no state, and it does not restart that bank's precharge-age counter.
- R3: A read or write to a closed bank pulses `err_rw_closed`.
- R4: Let d be the number of clocks between an open bank's activate and a read or write to it. The read or write pulses `err_rcd` when d + `add_lat` < T_RCD.
- R5: While `add_lat` is greater than 4, `err_al_cfg` is high. It follows the input with one cycle of delay.
- R6: An activate to a bank that is already open pulses `err_act_open`.
- R7: An activate to a bank fewer than T_RC = T_RAS + T_RP clocks after that bank's previous activate pulses `err_rc`.
- R8: An activate fewer than T_RRD clocks after an activate to a different bank pulses `err_rrd`.
- R9: A precharge to an open bank fewer than T_RAS clocks after its activate pulses `err_ras`.
- R10: An activate fewer than T_RP clocks after a precharge that closed the same bank pulses `err_rp`.
- R11: Synchronous active-low reset closes all banks, clears the outputs and marks every counter expired, so the first commands after reset raise no timing error. The counters saturate, so a long idle gap never makes an old event look recent.
- R12: A read or write to an open bank loads `rw_row` with the row latched by that bank's activate. At other times `rw_row` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock, rising edge samples |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank address |
| row_addr | input | 14 | Row address, used with activate |
| add_lat | input | 3 | Programmed additive latency |
| err_rcd | output | 1 | Read/write too early after activate |
| err_ras | output | 1 | Precharge too early after activate |
| err_rp | output | 1 | Activate too early after precharge |
| err_rc | output | 1 | Same-bank activate interval short |
| err_rrd | output | 1 | Cross-bank activate interval short |
| err_rw_closed | output | 1 | Read/write to a closed bank |
| err_act_open | output | 1 | Activate to an open bank |
| err_al_cfg | output | 1 | Additive latency outside 0..4 |
| bank_open | output | 8 | One bit per bank, high while open |
| rw_row | output | 14 | Row of the bank hit by the latest read/write |

## Verification
The properties assume that every strobe and the bank and latency inputs hold a known 0 or 1 at each sampling edge. They also assume that reset is held for at least one edge before the first command. The bench drives all inputs from tasks on the falling edge, and it returns to a deselect-free no-op pattern as soon as each command has been sampled. It also resets the monitor between scenarios, so every timing distance it expects is counted from a known activate or precharge edge.

// File: rtl/ddr2_mon_pkg.sv
package ddr2_mon_pkg;

   typedef enum logic [2:0] {
      CMD_NOP,
      CMD_ACT,
      CMD_RD,
      CMD_WR,
      CMD_PRE,
      CMD_OTHER
   } ddr2_cmd_e;

   // per-bank rule hits for one sampled command
   typedef struct packed {
      logic act_open;
      logic closed;
      logic rc;
      logic rp;
      logic ras;
      logic rcd;
   } bank_viol_t;

   localparam int AL_MAX = 4;

   function automatic logic is_rw(input ddr2_cmd_e c);
      return (c == CMD_RD) || (c == CMD_WR);
   endfunction

endpackage

// File: rtl/ddr2_cmd_decode.sv
module ddr2_cmd_decode
   import ddr2_mon_pkg::*;
#(
   parameter int BA_W      = 3,
   parameter int NUM_BANKS = 1 << BA_W
) (
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic [BA_W-1:0]      ba,
   output ddr2_cmd_e            cmd,
   output logic [NUM_BANKS-1:0] bank_sel
);

   always_comb begin
      if (cs_n) begin
         cmd = CMD_NOP;
      end else begin
         unique case ({ras_n, cas_n, we_n})
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b010:  cmd = CMD_PRE;
            3'b111:  cmd = CMD_NOP;
            default: cmd = CMD_OTHER;
         endcase
      end
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
      assign bank_sel[b] = (ba == BA_W'(b));
   end

endmodule

// File: rtl/ddr2_bank_timer.sv
module ddr2_bank_timer
   import ddr2_mon_pkg::*;
#(
   parameter int T_RCD = 3,
   parameter int T_RAS = 6,
   parameter int T_RP  = 3,
   parameter int CNT_W = 5,
   parameter int ROW_W = 14,
   parameter int AL_W  = 3,
   localparam int T_RC = T_RAS + T_RP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  ddr2_cmd_e        cmd,
   input  logic [AL_W-1:0]  add_lat,
   input  logic [ROW_W-1:0] row_in,
   output logic             is_open,
   output bank_viol_t       viol,
   output logic [ROW_W-1:0] row_q
);

   localparam logic [CNT_W-1:0] CNT_SAT = '1;
   localparam logic [CNT_W-1:0] LIM_RC  = CNT_W'(T_RC);
   localparam logic [CNT_W-1:0] LIM_RP  = CNT_W'(T_RP);
   localparam logic [CNT_W-1:0] LIM_RAS = CNT_W'(T_RAS);
   localparam logic [CNT_W:0]   LIM_RCD = (CNT_W+1)'(T_RCD);

   logic             open_q;
   logic [CNT_W-1:0] age_act;
   logic [CNT_W-1:0] age_pre;
   logic [CNT_W:0]   rcd_eff;
   logic             do_act;
   logic             do_rw;
   logic             do_pre;
   logic             closing;

   assign do_act  = hit && (cmd == CMD_ACT);
   assign do_rw   = hit && is_rw(cmd);
   assign do_pre  = hit && (cmd == CMD_PRE);
   assign closing = do_pre && open_q;
   assign rcd_eff = {1'b0, age_act} + (CNT_W+1)'(add_lat);

   always_comb begin
      viol          = '0;
      viol.act_open = do_act && open_q;
      viol.rc       = do_act && (age_act < LIM_RC);
      viol.rp       = do_act && (age_pre < LIM_RP);
      viol.closed   = do_rw && !open_q;
      viol.rcd      = do_rw && open_q && (rcd_eff < LIM_RCD);
      viol.ras      = closing && (age_act < LIM_RAS);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q  <= 1'b0;
         age_act <= CNT_SAT;
         age_pre <= CNT_SAT;
         row_q   <= '0;
      end else begin
         if (do_act)                 age_act <= CNT_W'(1);
         else if (age_act != CNT_SAT) age_act <= age_act + 1'b1;

         if (closing)                age_pre <= CNT_W'(1);
         else if (age_pre != CNT_SAT) age_pre <= age_pre + 1'b1;

         if (do_act)       open_q <= 1'b1;
         else if (closing) open_q <= 1'b0;

         if (do_act) row_q <= row_in;
      end
   end

   assign is_open = open_q;

endmodule

// File: rtl/ddr2_rrd_timer.sv
module ddr2_rrd_timer
   import ddr2_mon_pkg::*;
#(
   parameter int T_RRD = 2,
   parameter int BA_W  = 3,
   parameter int CNT_W = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  ddr2_cmd_e       cmd,
   input  logic [BA_W-1:0] ba,
   output logic            viol_rrd
);

   localparam logic [CNT_W-1:0] CNT_SAT = '1;
   localparam logic [CNT_W-1:0] LIM_RRD = CNT_W'(T_RRD);

   logic [CNT_W-1:0] age_q;
   logic [BA_W-1:0]  last_ba_q;
   logic             is_act;

   assign is_act   = (cmd == CMD_ACT);
   assign viol_rrd = is_act && (ba != last_ba_q) && (age_q < LIM_RRD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         age_q     <= CNT_SAT;
         last_ba_q <= '0;
      end else if (is_act) begin
         age_q     <= CNT_W'(1);
         last_ba_q <= ba;
      end else if (age_q != CNT_SAT) begin
         age_q <= age_q + 1'b1;
      end
   end

endmodule

// File: rtl/ddr2_act_timing_mon.sv
module ddr2_act_timing_mon
   import ddr2_mon_pkg::*;
#(
   parameter int BA_W  = 3,
   parameter int ROW_W = 14,
   parameter int AL_W  = 3,
   parameter int T_RCD = 3,
   parameter int T_RAS = 6,
   parameter int T_RP  = 3,
   parameter int T_RRD = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic [BA_W-1:0]      ba,
   input  logic [ROW_W-1:0]     row_addr,
   input  logic [AL_W-1:0]      add_lat,
   output logic                 err_rcd,
   output logic                 err_ras,
   output logic                 err_rp,
   output logic                 err_rc,
   output logic                 err_rrd,
   output logic                 err_rw_closed,
   output logic                 err_act_open,
   output logic                 err_al_cfg,
   output logic [(1<<BA_W)-1:0] bank_open,
   output logic [ROW_W-1:0]     rw_row
);

   localparam int NUM_BANKS = 1 << BA_W;
   localparam int T_RC      = T_RAS + T_RP;
   localparam int CNT_W     = $clog2(T_RC + T_RCD + 1) + 1;

   // elaboration-time parameter checks
   if (BA_W < 1 || BA_W > 4) begin : g_bad_ba
      $error("BA_W out of range");
   end
   if (T_RCD < 1 || T_RAS < 1 || T_RP < 1 || T_RRD < 1) begin : g_bad_t
      $error("timing parameters must be at least one clock");
   end
   if (AL_W < 3 || AL_W >= CNT_W) begin : g_bad_al
      $error("AL_W must hold 4 and fit below the counter width");
   end
   if (ROW_W < 1) begin : g_bad_row
      $error("ROW_W must be positive");
   end

   ddr2_cmd_e              cmd;
   logic [NUM_BANKS-1:0]   bank_sel;
   logic [NUM_BANKS-1:0]   open_vec;
   bank_viol_t             bviol [NUM_BANKS];
   logic [ROW_W-1:0]       brow  [NUM_BANKS];
   logic [NUM_BANKS-1:0]   v_rcd, v_ras, v_rp, v_rc, v_closed, v_open;
   logic                   v_rrd;

   ddr2_cmd_decode #(
      .BA_W      (BA_W),
      .NUM_BANKS (NUM_BANKS)
   ) u_dec (
      .cs_n     (cs_n),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .we_n     (we_n),
      .ba       (ba),
      .cmd      (cmd),
      .bank_sel (bank_sel)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      ddr2_bank_timer #(
         .T_RCD (T_RCD),
         .T_RAS (T_RAS),
         .T_RP  (T_RP),
         .CNT_W (CNT_W),
         .ROW_W (ROW_W),
         .AL_W  (AL_W)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .hit     (bank_sel[b]),
         .cmd     (cmd),
         .add_lat (add_lat),
         .row_in  (row_addr),
         .is_open (open_vec[b]),
         .viol    (bviol[b]),
         .row_q   (brow[b])
      );
      assign v_rcd[b]    = bviol[b].rcd;
      assign v_ras[b]    = bviol[b].ras;
      assign v_rp[b]     = bviol[b].rp;
      assign v_rc[b]     = bviol[b].rc;
      assign v_closed[b] = bviol[b].closed;
      assign v_open[b]   = bviol[b].act_open;
   end

   ddr2_rrd_timer #(
      .T_RRD (T_RRD),
      .BA_W  (BA_W),
      .CNT_W (CNT_W)
   ) u_rrd (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .ba       (ba),
      .viol_rrd (v_rrd)
   );

   logic rw_hit;
   assign rw_hit = is_rw(cmd) && open_vec[ba];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_rcd       <= 1'b0;
         err_ras       <= 1'b0;
         err_rp        <= 1'b0;
         err_rc        <= 1'b0;
         err_rrd       <= 1'b0;
         err_rw_closed <= 1'b0;
         err_act_open  <= 1'b0;
         err_al_cfg    <= 1'b0;
         rw_row        <= '0;
      end else begin
         err_rcd       <= |v_rcd;
         err_ras       <= |v_ras;
         err_rp        <= |v_rp;
         err_rc        <= |v_rc;
         err_rrd       <= v_rrd;
         err_rw_closed <= |v_closed;
         err_act_open  <= |v_open;
         err_al_cfg    <= (add_lat > AL_W'(AL_MAX));
         if (rw_hit) rw_row <= brow[ba];
      end
   end

   assign bank_open = open_vec;

endmodule

// File: rtl/ddr2_act_timing_mon_chk.sv
module ddr2_act_timing_mon_chk #(
   parameter int BA_W  = 3,
   parameter int ROW_W = 14,
   parameter int AL_W  = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cs_n,
   input logic                 ras_n,
   input logic                 cas_n,
   input logic                 we_n,
   input logic [BA_W-1:0]      ba,
   input logic [ROW_W-1:0]     row_addr,
   input logic [AL_W-1:0]      add_lat,
   input logic                 err_rcd,
   input logic                 err_ras,
   input logic                 err_rp,
   input logic                 err_rc,
   input logic                 err_rrd,
   input logic                 err_rw_closed,
   input logic                 err_act_open,
   input logic                 err_al_cfg,
   input logic [(1<<BA_W)-1:0] bank_open,
   input logic [ROW_W-1:0]     rw_row
);

   logic act_c, pre_c, rw_c, rule_err;
   assign act_c    = !cs_n && !ras_n &&  cas_n &&  we_n;
   assign pre_c    = !cs_n && !ras_n &&  cas_n && !we_n;
   assign rw_c     = !cs_n &&  ras_n && !cas_n;
   assign rule_err = err_rcd | err_ras | err_rp | err_rc | err_rrd
                   | err_rw_closed | err_act_open;

   assert_desel_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> $stable(bank_open));

   assert_desel_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !rule_err);

   assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
      act_c |=> bank_open[$past(ba)]);

   assert_pre_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pre_c |=> !bank_open[$past(ba)]);

   assert_rw_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rw_c && !bank_open[ba]) |=> err_rw_closed);

   assert_al_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (add_lat > AL_W'(4)) |=> err_al_cfg);

   assert_act_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (act_c && bank_open[ba]) |=> err_act_open);

   assert_rc_after_act_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_rc |-> $past(act_c));

   assert_ras_after_pre_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_ras |-> $past(pre_c));

   assert_row_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !rw_c |=> $stable(rw_row));

endmodule

bind ddr2_act_timing_mon ddr2_act_timing_mon_chk #(
   .BA_W  (BA_W),
   .ROW_W (ROW_W),
   .AL_W  (AL_W)
) u_chk (.*);

// File: tb/ddr2_act_timing_mon_tb.sv
module ddr2_act_timing_mon_tb;

   localparam logic [2:0] P_ACT = 3'b011;
   localparam logic [2:0] P_RD  = 3'b101;
   localparam logic [2:0] P_WR  = 3'b100;
   localparam logic [2:0] P_PRE = 3'b010;
   localparam logic [2:0] P_REF = 3'b001;
   localparam logic [2:0] P_MRS = 3'b000;
   localparam logic [2:0] P_NOP = 3'b111;

   // bench error vector bit order
   localparam logic [7:0] E_RCD = 8'h01, E_RAS = 8'h02, E_RP  = 8'h04,
                          E_RC  = 8'h08, E_RRD = 8'h10, E_CLS = 8'h20,
                          E_OPN = 8'h40, E_AL  = 8'h80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [2:0]  ba = '0;
   logic [13:0] row_addr = '0;
   logic [2:0]  add_lat = '0;
   logic        err_rcd, err_ras, err_rp, err_rc, err_rrd;
   logic        err_rw_closed, err_act_open, err_al_cfg;
   logic [7:0]  bank_open;
   logic [13:0] rw_row;

   int total = 0;
   int bad   = 0;
   logic [7:0] seen;

   always #10 clk = ~clk;

   ddr2_act_timing_mon u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .row_addr(row_addr), .add_lat(add_lat),
      .err_rcd(err_rcd), .err_ras(err_ras), .err_rp(err_rp), .err_rc(err_rc),
      .err_rrd(err_rrd), .err_rw_closed(err_rw_closed),
      .err_act_open(err_act_open), .err_al_cfg(err_al_cfg),
      .bank_open(bank_open), .rw_row(rw_row)
   );

   function automatic logic [7:0] errs_now();
      return {err_al_cfg, err_act_open, err_rw_closed, err_rrd,
              err_rc, err_rp, err_ras, err_rcd};
   endfunction

   task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check14(input logic [13:0] act, input logic [13:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic [2:0] al);
      @(negedge clk);
      rst_n = 1'b0; cs_n = 1'b1; {ras_n, cas_n, we_n} = P_NOP; add_lat = al;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // drive one command for one edge, capture the error vector just after it
   task automatic issue(input logic csn, input logic [2:0] pat,
                        input logic [2:0] bank, input logic [13:0] row);
      @(negedge clk);
      cs_n = csn; {ras_n, cas_n, we_n} = pat; ba = bank; row_addr = row;
      @(posedge clk);
      #2;
      seen = errs_now();
      cs_n = 1'b0; {ras_n, cas_n, we_n} = P_NOP;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic t_reset();
      do_reset(3'd0);
      idle(1);
      check8(bank_open, 8'h00, "R11 banks closed after reset");
      check8(errs_now(), 8'h00, "R11 errors clear after reset");
      check14(rw_row, 14'h0, "R11 rw_row clear after reset");
      issue(1'b0, P_ACT, 3'd0, 14'd5);
      check8(seen, 8'h00, "R11 first activate after reset clean");
      check8(bank_open, 8'h01, "R2 activate opens bank 0");
   endtask

   task automatic t_decode();
      do_reset(3'd0);
      issue(1'b1, P_ACT, 3'd0, 14'd1);
      check8(bank_open, 8'h00, "R1 deselected activate ignored");
      check8(seen, 8'h00, "R1 deselected activate no error");
      issue(1'b0, P_REF, 3'd0, 14'd1);
      check8(bank_open | seen, 8'h00, "R1 refresh pattern ignored");
      issue(1'b0, P_MRS, 3'd1, 14'd1);
      check8(bank_open | seen, 8'h00, "R1 mode pattern ignored");
      issue(1'b0, P_ACT, 3'd0, 14'd1);
      check8(bank_open, 8'h01, "R1 selected activate decoded");
      idle(8);
      issue(1'b1, P_PRE, 3'd0, 14'd0);
      check8(bank_open, 8'h01, "R1 deselected precharge ignored");
   endtask

   task automatic t_rcd();
      do_reset(3'd0);
      issue(1'b0, P_ACT, 3'd1, 14'd0);
      issue(1'b0, P_RD, 3'd1, 14'd0);
      check8(seen, E_RCD, "R4 read d=1 al=0");
      do_reset(3'd2);
      issue(1'b0, P_ACT, 3'd1, 14'd0);
      issue(1'b0, P_RD, 3'd1, 14'd0);
      check8(seen, 8'h00, "R4 read d=1 al=2 boundary");
      do_reset(3'd1);
      issue(1'b0, P_ACT, 3'd1, 14'd0);
      issue(1'b0, P_WR, 3'd1, 14'd0);
      check8(seen, E_RCD, "R4 write d=1 al=1");
      do_reset(3'd0);
      issue(1'b0, P_ACT, 3'd1, 14'd0);
      idle(1);
      issue(1'b0, P_WR, 3'd1, 14'd0);
      check8(seen, E_RCD, "R4 write d=2 al=0");
      issue(1'b0, P_WR, 3'd1, 14'd0);
      check8(seen, 8'h00, "R4 write d=3 al=0 boundary");
   endtask

   task automatic t_closed();
      do_reset(3'd0);
      issue(1'b0, P_RD, 3'd2, 14'd0);
      check8(seen, E_CLS, "R3 read closed bank");
      issue(1'b0, P_WR, 3'd2, 14'd0);
      check8(seen, E_CLS, "R3 write closed bank");
   endtask

   task automatic t_act_open();
      do_reset(3'd0);
      issue(1'b0, P_ACT, 3'd3, 14'd0);
      idle(10);
      issue(1'b0, P_ACT, 3'd3, 14'd0);
      check8(seen, E_OPN, "R6 activate open bank");
   endtask

   task automatic t_rc_rp();
      do_reset(3'd0);
      issue(1'b0, P_ACT, 3'd4, 14'd0);
      idle(5);
      issue(1'b0, P_PRE, 3'd4, 14'd0);
      check8(seen, 8'h00, "R9 precharge at d=6 legal");
      check8(bank_open, 8'h00, "R2 precharge closes bank 4");
      idle(1);
      issue(1'b0, P_ACT, 3'd4, 14'd0);
      check8(seen, E_RC | E_RP, "R7 R10 reactivate too soon");
      do_reset(3'd0);
      issue(1'b0, P_ACT, 3'd5, 14'd0);
      idle(5);
      issue(1'b0, P_PRE, 3'd5, 14'd0);
      idle(2);
      issue(1'b0, P_ACT, 3'd5, 14'd0);
      check8(seen, 8'h00, "R7 R10 reactivate at limits");
      do_reset(3'd0);
      issue(1'b0, P_ACT, 3'd6, 14'd0);
      idle(2);
      issue(1'b0, P_PRE, 3'd6, 14'd0);
      check8(seen, E_RAS, "R9 precharge at d=3");
      check8(bank_open, 8'h00, "R2 early precharge still closes");
      idle(2);
      issue(1'b0, P_ACT, 3'd6, 14'd0);
      check8(seen, E_RC, "R7 tRC alone at d=6");
   endtask

   task automatic t_rrd();
      do_reset(3'd0);
      issue(1'b0, P_ACT, 3'd0, 14'd0);
      issue(1'b0, P_ACT, 3'd1, 14'd0);
      check8(seen, E_RRD, "R8 cross-bank activate d=1");
      idle(1);
      issue(1'b0, P_ACT, 3'd2, 14'd0);
      check8(seen, 8'h00, "R8 cross-bank activate d=2");
      check8(bank_open, 8'h07, "R2 three banks open");
   endtask

   task automatic t_pre_closed();
      do_reset(3'd0);
      issue(1'b0, P_PRE, 3'd7, 14'd0);
      check8(seen | bank_open, 8'h00, "R2 precharge closed bank no effect");
      issue(1'b0, P_ACT, 3'd7, 14'd0);
      check8(seen, 8'h00, "R2 no tRP restart from idle precharge");
   endtask

   task automatic t_al();
      do_reset(3'd0);
      add_lat = 3'd5;
      idle(1);
      check8(errs_now(), E_AL, "R5 al=5 flagged");
      add_lat = 3'd4;
      idle(1);
      check8(errs_now(), 8'h00, "R5 al=4 accepted");
      add_lat = 3'd7;
      idle(1);
      check8(errs_now(), E_AL, "R5 al=7 flagged");
      add_lat = 3'd0;
      idle(1);
   endtask

   task automatic t_row();
      do_reset(3'd0);
      issue(1'b0, P_ACT, 3'd2, 14'h1234);
      idle(1);
      issue(1'b0, P_ACT, 3'd3, 14'h0abc);
      idle(3);
      issue(1'b0, P_RD, 3'd2, 14'h3fff);
      check14(rw_row, 14'h1234, "R12 read reports bank 2 row");
      issue(1'b0, P_WR, 3'd3, 14'h0000);
      check14(rw_row, 14'h0abc, "R12 write reports bank 3 row");
      issue(1'b0, P_RD, 3'd5, 14'h0111);
      check14(rw_row, 14'h0abc, "R12 closed-bank read holds row");
   endtask

   task automatic t_sat();
      do_reset(3'd0);
      issue(1'b0, P_ACT, 3'd0, 14'd0);
      idle(32);
      issue(1'b0, P_PRE, 3'd0, 14'd0);
      check8(seen, 8'h00, "R11 counter saturates over long gap");
   endtask

   logic done = 1'b0;

   initial begin
      #(20 * 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_decode();
      t_rcd();
      t_closed();
      t_act_open();
      t_rc_rp();
      t_rrd();
      t_pre_closed();
      t_al();
      t_row();
      t_sat();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule